// File: doc/BRIEF.md
# Charger Power Dissipation Limiter

This block keeps the heat generated in the external charge-path pass transistors within a budget chosen by a 2-bit code. Time advances on a 1 ms tick. Once every 500 ms control period the block multiplies a sampled voltage-drop code by a sampled charge-current code to get the dissipated power. It divides the budget by that power to find the duty cycle the drivers can sustain. That duty cycle is loaded at the period boundary and applied as a 100-step PWM on the pass-transistor driver enable. While gating is in effect, a separate output holds the system bypass transistor on.

For the first 1500 ms after charging is enabled, the gating is suppressed so that start-up transients do not trip the limiter, but the duty cycle is still estimated. If the required duty falls below 10%, at any time, the charge path is shut off. A one-cycle interrupt is raised and a 2-bit cause code reads 01. The fault persists until charging is switched off and on again. A disable input, a factory-mode input or a reverse-mode input each take the limiter fully out of the loop.

Top module: `chg_pwr_limiter`

## Requirements
- R1: The budget code maps to a limit of 600 mW (00), 800 mW (01), 1000 mW (10) or 1200 mW (11). One unit of the voltage×current product equals 2 mW, so the limits are 300, 400, 500 and 600 product units.
- R2: Power is the unsigned product of the 10-bit voltage and current codes. The duty in percent is floor(100 × limit / power), or 100 when power ≤ limit. Outside blanking, with m the milliseconds since enable modulo 500, the drivers are on exactly when floor(m / 5) < duty.
- R3: Inputs are sampled, and the duty is updated, only on the tick that closes each 500 ms period counted from enable. Changing the inputs mid-period leaves the gating unchanged until that boundary.
- R4: For the first 1500 ticks after enable, the drivers stay continuously on and the bypass output stays low.
- R5: At a period boundary, a computed duty below 10 disables the charge path, both during and after blanking. A duty of exactly 10 does not.
- R6: On that fault, the interrupt is high for exactly one cycle, in the cycle the path turns off. The cause code then reads 01; it reads 00 when there is no fault.
- R7: A fault holds the path and the drivers off until the charge enable is low. One cycle after the enable goes low, the code reads 00. Re-enabling restarts the period timing and the blanking window.
- R8: While the disable, factory-mode or reverse-mode input is high, the drivers follow the charge path enable, no fault is raised, and the bypass output stays low.
- R9: The bypass output is high exactly when the path is enabled, the limiter is active and out of blanking, and the applied duty is below 100.
- R10: After reset, with the enable low, all outputs are low and the code reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| chg_en | input | 1 | Charging enabled |
| lim_dis | input | 1 | Limiter disable |
| factory_mode | input | 1 | Factory serial-path mode, bypasses limiter |
| reverse_mode | input | 1 | Reverse supply mode, bypasses limiter |
| budget_code | input | 2 | Power budget selection |
| vdrop_code | input | 10 | Sampled voltage across the pass devices |
| ichg_code | input | 10 | Sampled charge current |
| drv_gate | output | 1 | Pass-transistor driver enable |
| bypass_on | output | 1 | Bypass transistor forced on |
| chg_path_en | output | 1 | Charge path enabled |
| fault_irq | output | 1 | One-cycle fault interrupt |
| fault_code | output | 2 | Fault cause (01 = minimum duty) |

## Verification
The hardest situations to reach are the cutoff edge and the fault raised inside the blanking window. In the first, a power of exactly ten times the budget must keep charging, while one product step beyond it must stop charging. In the second, the drivers look fully on until the very tick that ends the first period. The stimulus reaches both by choosing voltage and current codes whose product lands on 4000 and on 4004 against the 800 mW budget, and 4000 against 600 mW. The tick is held high every clock, so the 500 ms and 1500 ms windows pass in a few thousand cycles. Mid-period input changes are used to show that the duty only moves at boundaries.

// File: rtl/plim_pkg.sv
// Shared constants and helpers for the charger power limiter.
package plim_pkg;
    localparam int PCT    = 100;  // PWM steps per period, duty in percent
    localparam int DUTY_W = 7;    // holds 0..100
    typedef logic [DUTY_W-1:0] duty_t;

    // Budget in milliwatts for a 2-bit code.
    function automatic int budget_mw(input logic [1:0] code);
        return 600 + 200 * int'(code);
    endfunction
endpackage

// File: rtl/plim_timebase.sv
// Millisecond timebase: position inside the control period and the
// start-up blanking flag. Assumes tick is a single-cycle pulse.
// Everything is held at zero while run is low.
module plim_timebase #(
    parameter int PERIOD_MS = 500,
    parameter int BLANK_MS  = 1500,
    localparam int MS_W = $clog2(PERIOD_MS),
    localparam int EL_W = $clog2(BLANK_MS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    output logic [MS_W-1:0] ms_cnt,
    output logic            period_end,
    output logic            blanking
);
    logic [EL_W-1:0] elapsed;

    assign period_end = run && tick && (ms_cnt == MS_W'(PERIOD_MS - 1));
    assign blanking   = elapsed < EL_W'(BLANK_MS);

    // Advance period position and saturating elapsed time on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ms_cnt  <= '0;
            elapsed <= '0;
        end else if (tick) begin
            ms_cnt <= period_end ? '0 : ms_cnt + 1'b1;
            if (blanking) elapsed <= elapsed + 1'b1;
        end
    end

    a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (ms_cnt == '0));
endmodule

// File: rtl/plim_duty_calc.sv
// Combinational power and duty estimate: power = v*i, duty =
// floor(100*limit/power), saturated at 100. Assumes the limit is nonzero.
module plim_duty_calc
    import plim_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int PWR_LSB_UW = 2000,
    parameter int MIN_DUTY   = 10,
    localparam int PWR_W = 2 * CODE_W
) (
    input  logic [1:0]        budget_code,
    input  logic [CODE_W-1:0] v_code,
    input  logic [CODE_W-1:0] i_code,
    output duty_t             duty,
    output logic              below_min
);
    logic [PWR_W-1:0] power;
    logic [31:0]      lim_units;
    logic [31:0]      quot;

    // Compute power, the budget in product units and the affordable duty.
    always_comb begin
        power     = {{CODE_W{1'b0}}, v_code} * {{CODE_W{1'b0}}, i_code};
        lim_units = 32'(budget_mw(budget_code) * 1000 / PWR_LSB_UW);
        quot      = '0;
        if (32'(power) <= lim_units) begin
            duty = DUTY_W'(PCT);
        end else begin
            quot = (lim_units * 32'(PCT)) / 32'(power);
            duty = DUTY_W'(quot);
        end
        below_min = duty < DUTY_W'(MIN_DUTY);
    end
endmodule

// File: rtl/plim_pwm.sv
// Holds the applied duty (loaded only at period boundaries) and turns
// the period position into a 100-step on/off pattern. Duty resets to 100.
module plim_pwm
    import plim_pkg::*;
#(
    parameter int PERIOD_MS = 500,
    localparam int MS_W    = $clog2(PERIOD_MS),
    localparam int STEP_MS = PERIOD_MS / PCT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            load,
    input  duty_t           duty_in,
    input  logic [MS_W-1:0] ms_cnt,
    output duty_t           duty_q,
    output logic            pwm_on
);
    logic [MS_W-1:0] step;

    assign step   = ms_cnt / MS_W'(STEP_MS);
    assign pwm_on = 32'(step) < 32'(duty_q);

    // Capture the new duty at each boundary; full duty when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) duty_q <= DUTY_W'(PCT);
        else if (load)      duty_q <= duty_in;
    end

    a_r3_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> $stable(duty_q));
endmodule

// File: rtl/chg_pwr_limiter.sv
// Charger power dissipation limiter top. Assumes vdrop/ichg codes are
// already sampled and stable around period boundaries and that tick_1ms
// is a one-cycle pulse. Latches a min-duty fault until chg_en drops.
module chg_pwr_limiter
    import plim_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int PERIOD_MS  = 500,
    parameter int BLANK_MS   = 1500,
    parameter int MIN_DUTY   = 10,
    parameter int PWR_LSB_UW = 2000,
    localparam int MS_W = $clog2(PERIOD_MS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic              chg_en,
    input  logic              lim_dis,
    input  logic              factory_mode,
    input  logic              reverse_mode,
    input  logic [1:0]        budget_code,
    input  logic [CODE_W-1:0] vdrop_code,
    input  logic [CODE_W-1:0] ichg_code,
    output logic              drv_gate,
    output logic              bypass_on,
    output logic              chg_path_en,
    output logic              fault_irq,
    output logic [1:0]        fault_code
);
    logic [MS_W-1:0] ms_cnt;
    logic            period_end, blanking, pwm_on, below_min;
    logic            lim_off, limiting, fault_q, irq_q, trip;
    duty_t           duty_est, duty_q;

    plim_timebase #(.PERIOD_MS(PERIOD_MS), .BLANK_MS(BLANK_MS)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(chg_en), .tick(tick_1ms),
        .ms_cnt(ms_cnt), .period_end(period_end), .blanking(blanking));

    plim_duty_calc #(.CODE_W(CODE_W), .PWR_LSB_UW(PWR_LSB_UW),
                     .MIN_DUTY(MIN_DUTY)) u_calc (
        .budget_code(budget_code), .v_code(vdrop_code), .i_code(ichg_code),
        .duty(duty_est), .below_min(below_min));

    plim_pwm #(.PERIOD_MS(PERIOD_MS)) u_pwm (
        .clk(clk), .rst_n(rst_n), .run(chg_en), .load(period_end),
        .duty_in(duty_est), .ms_cnt(ms_cnt), .duty_q(duty_q), .pwm_on(pwm_on));

    assign lim_off     = lim_dis || factory_mode || reverse_mode;
    assign trip        = chg_en && !lim_off && period_end && below_min && !fault_q;
    assign chg_path_en = chg_en && !fault_q;
    assign limiting    = chg_path_en && !lim_off && !blanking;
    assign drv_gate    = chg_path_en && (!limiting || pwm_on);
    assign bypass_on   = limiting && (duty_q < DUTY_W'(PCT));
    assign fault_irq   = irq_q;
    assign fault_code  = fault_q ? 2'b01 : 2'b00;

    // Latch the min-duty fault and emit a single-cycle interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || !chg_en) begin
            fault_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= trip;
            if (trip) fault_q <= 1'b1;
        end
    end

    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |=> !fault_irq);
    a_r6_code_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |-> (fault_code == 2'b01));
    a_r7_off_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 2'b00) |-> (!drv_gate && !chg_path_en));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en |=> (fault_code == 2'b00));
    a_r8_full_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_dis && chg_path_en) |-> (drv_gate && !bypass_on));
    a_r9_bypass_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_on |-> (chg_path_en && !blanking));
    a_r4_blank_full: assert property (@(posedge clk) disable iff (!rst_n)
        (blanking && chg_path_en) |-> drv_gate);
endmodule

// File: tb/chg_pwr_limiter_test.sv
module chg_pwr_limiter_test;
    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b1, chg_en = 1'b0;
    logic       lim_dis = 1'b0, factory_mode = 1'b0, reverse_mode = 1'b0;
    logic [1:0] budget_code = 2'b00;
    logic [9:0] vdrop_code = '0, ichg_code = '0;
    logic       drv_gate, bypass_on, chg_path_en, fault_irq;
    logic [1:0] fault_code;

    typedef struct {
        int         due;
        logic       g, b, p, irq;
        logic [1:0] code;
        string      req;
    } exp_t;
    exp_t q[$];
    int ncnt = 0, n_vec = 0, n_bad = 0, base = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    chg_pwr_limiter uut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .chg_en(chg_en),
        .lim_dis(lim_dis), .factory_mode(factory_mode), .reverse_mode(reverse_mode),
        .budget_code(budget_code), .vdrop_code(vdrop_code), .ichg_code(ichg_code),
        .drv_gate(drv_gate), .bypass_on(bypass_on), .chg_path_en(chg_path_en),
        .fault_irq(fault_irq), .fault_code(fault_code));

    // Monitor: on every falling edge, compare due scoreboard entries.
    always @(negedge clk) begin
        ncnt++;
        while (q.size() > 0 && q[0].due <= ncnt) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (e.due != ncnt ||
                {drv_gate, bypass_on, chg_path_en, fault_irq, fault_code} !==
                {e.g, e.b, e.p, e.irq, e.code}) begin
                n_bad++;
                $display("FAIL %s at %0d: got g%b b%b p%b irq%b code%b, exp g%b b%b p%b irq%b code%b",
                         e.req, ncnt, drv_gate, bypass_on, chg_path_en, fault_irq,
                         fault_code, e.g, e.b, e.p, e.irq, e.code);
            end
        end
        if (ncnt > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Driver: push one expected observation at an absolute falling edge.
    task automatic expect_at(input int due, input logic g, input logic b,
                             input logic p, input logic [1:0] c,
                             input logic irq, input string r);
        exp_t e;
        e.due = due; e.g = g; e.b = b; e.p = p; e.code = c; e.irq = irq; e.req = r;
        q.push_back(e);
    endtask

    task automatic wait_until(input int t);
        while (ncnt < t) @(negedge clk);
        #1;
    endtask

    task automatic load(input logic [1:0] bc, input int v, input int i);
        budget_code = bc; vdrop_code = 10'(v); ichg_code = 10'(i);
    endtask

    task automatic start();
        @(negedge clk); #1;
        chg_en = 1'b1;
        base = ncnt;
    endtask

    task automatic stop(input string r);
        @(negedge clk); #1;
        chg_en = 1'b0;
        expect_at(ncnt + 1, 0, 0, 0, 2'b00, 0, r);
        wait_until(ncnt + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        expect_at(ncnt + 1, 0, 0, 0, 2'b00, 0, "R10 reset");
        wait_until(ncnt + 2);

        // Power under budget: full duty, no bypass (R2, R4)
        load(2'b00, 10, 20); start();
        expect_at(base + 10,   1, 0, 1, 2'b00, 0, "R4 blank on");
        expect_at(base + 1700, 1, 0, 1, 2'b00, 0, "R2 saturated duty");
        expect_at(base + 1999, 1, 0, 1, 2'b00, 0, "R2 last step");
        wait_until(base + 1999); stop("R7 idle");

        // 600 units against 300 -> 50%; mid-period change to 25% (R2, R3, R4, R9)
        load(2'b00, 20, 30); start();
        expect_at(base + 1499, 1, 0, 1, 2'b00, 0, "R4 blank end");
        expect_at(base + 1510, 1, 1, 1, 2'b00, 0, "R9 bypass on");
        wait_until(base + 1600); ichg_code = 10'd60;
        expect_at(base + 1700, 1, 1, 1, 2'b00, 0, "R3 old duty held");
        expect_at(base + 1760, 0, 1, 1, 2'b00, 0, "R2 off step");
        expect_at(base + 1999, 0, 1, 1, 2'b00, 0, "R2 final step");
        expect_at(base + 2120, 1, 1, 1, 2'b00, 0, "R3 new duty on");
        expect_at(base + 2200, 0, 1, 1, 2'b00, 0, "R3 new duty off");
        wait_until(base + 2200); stop("R7 idle");

        // Budget codes 11 and 10 against 1000 units (R1)
        load(2'b11, 20, 50); start();
        expect_at(base + 1795, 1, 1, 1, 2'b00, 0, "R1 code11 on");
        expect_at(base + 1800, 0, 1, 1, 2'b00, 0, "R1 code11 off");
        wait_until(base + 1900); budget_code = 2'b10;
        expect_at(base + 2245, 1, 1, 1, 2'b00, 0, "R1 code10 on");
        expect_at(base + 2250, 0, 1, 1, 2'b00, 0, "R1 code10 off");
        wait_until(base + 2250); stop("R7 idle");

        // Fault inside blanking: 4000 against 300 (R5, R6, R7)
        load(2'b00, 100, 40); start();
        expect_at(base + 499,  1, 0, 1, 2'b00, 0, "R5 before boundary");
        expect_at(base + 500,  0, 0, 0, 2'b01, 1, "R6 fault irq");
        expect_at(base + 501,  0, 0, 0, 2'b01, 0, "R6 irq single");
        expect_at(base + 1600, 0, 0, 0, 2'b01, 0, "R7 latched");
        wait_until(base + 1600); stop("R7 clear");

        // Exactly 10% is allowed, one step over faults (R5, R1 code01)
        load(2'b01, 100, 40); start();
        expect_at(base + 500,  1, 0, 1, 2'b00, 0, "R5 ten percent ok");
        expect_at(base + 1545, 1, 1, 1, 2'b00, 0, "R5 ten percent on");
        expect_at(base + 1550, 0, 1, 1, 2'b00, 0, "R5 ten percent off");
        wait_until(base + 1600); load(2'b01, 91, 44);
        expect_at(base + 2000, 0, 0, 0, 2'b01, 1, "R5 fault after blank");
        wait_until(base + 2000); stop("R7 clear");

        // Re-enable restarts blanking (R7)
        load(2'b00, 20, 30); start();
        expect_at(base + 1499, 1, 0, 1, 2'b00, 0, "R7 blank restarted");
        expect_at(base + 1510, 1, 1, 1, 2'b00, 0, "R7 limiting resumes");
        wait_until(base + 1510); stop("R7 idle");

        // Limiter bypass by disable, factory and reverse (R8)
        lim_dis = 1'b1; load(2'b00, 100, 40); start();
        expect_at(base + 500,  1, 0, 1, 2'b00, 0, "R8 disable no fault");
        expect_at(base + 1999, 1, 0, 1, 2'b00, 0, "R8 disable full on");
        wait_until(base + 1999); stop("R7 idle"); lim_dis = 1'b0;
        factory_mode = 1'b1; start();
        expect_at(base + 501,  1, 0, 1, 2'b00, 0, "R8 factory");
        wait_until(base + 501); stop("R7 idle"); factory_mode = 1'b0;
        reverse_mode = 1'b1; start();
        expect_at(base + 1700, 1, 0, 1, 2'b00, 0, "R8 reverse");
        wait_until(base + 1700); stop("R7 idle"); reverse_mode = 1'b0;

        wait_until(ncnt + 2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule